// File: doc/BRIEF.md
# Store Queue with Commit Marking and In-Order Writeback

This block holds the stores of an out-of-order core between dispatch and the moment the data cache has finished with them. Each store gets a slot when it is dispatched. The slot keeps the store's sequence number, address, byte size, data word and the load-queue tail seen at insertion. Commit broadcasts the youngest retired sequence number, and every matching entry becomes eligible for writeback. The eligible stores are then sent to the data cache one per cycle, in program order, over a valid/ready request port.

Three pointers run over a circular array that has one slot more than the capacity: head (oldest live entry), writeback (next entry to send) and tail (next free slot). Cache responses may complete entries in any order. The head retires only across an unbroken run of completed entries. A squash trims speculative stores from the tail and never removes an entry that has already been committed. A load that waits on a particular store is released for replay when that store is accepted by the cache or completes.

Top module: `sq_store_queue`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `count`=0, `pending`=0, `reqValid`=0 and `replayValid`=0.
- R2: Slots are numbered 0..DEPTH and `allocIdx` names the slot the next store will take. Each accepted `allocValid` raises `count` by one and moves `allocIdx` forward by one, wrapping from DEPTH to 0. `full` rises when `count` reaches DEPTH, and an allocation while full has no effect.
- R3: Every entry keeps the `allocLqTail` value seen when it was allocated, and `headLqTag` shows that value for the oldest live entry.
- R4: A commit marks every live, not-yet-ready entry whose sequence number is unsigned-less-than-or-equal to `commitSeq`, and `pending` grows by the number of entries marked. An entry that is not ready is never sent.
- R5: A `condValid` pulse marks the live entry at `condIdx` ready without any commit, and adds one to `pending`.
- R6: `reqValid` presents the oldest ready entry that has not yet been written back, with its slot, address, data and size. Entries are sent in program order, at most one per cycle, and the writeback pointer advances only on acceptance.
- R7: A cycle with `reqValid`=1 and `reqReady`=0 sets a sticky block. From the next cycle `reqValid` stays low until a `retry` pulse, after which the same entry is offered again.
- R8: A ready entry of size 0 at the writeback pointer completes in one cycle without raising `reqValid`.
- R9: A completion (`cplValid`, `cplIdx`) marks the entry done. The head retires over every consecutive done entry, and `count` drops by one per entry retired. A completed entry behind an incomplete older one keeps its slot.
- R10: A squash removes from the tail the entries whose sequence number exceeds `squashSeq`. It stops at the first entry, walking back, that is ready. Allocation, commit and conditional marking in the squash cycle have no effect.
- R11: While a load is stalled on store slot S, the cycle in which S is accepted by the cache or completes is followed by a one-cycle `replayValid` pulse carrying the stalled load index. The stall then clears.
- R12: `pending` drops by one for each entry that completes, including zero-size entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Insert a new store |
| allocSeq | input | SEQ_W | Sequence number of the new store |
| allocAddr | input | ADDR_W | Store address |
| allocSize | input | SIZE_W | Store size in bytes (0 means nothing to write) |
| allocData | input | DATA_W | Store data word |
| allocLqTail | input | LQ_W | Load-queue tail at insertion |
| allocIdx | output | IDX_W | Slot the next store will occupy |
| full | output | 1 | DEPTH entries live |
| empty | output | 1 | No entry live |
| count | output | CNT_W | Live entries |
| pending | output | CNT_W | Ready entries not yet completed |
| commitValid | input | 1 | Commit broadcast |
| commitSeq | input | SEQ_W | Youngest committed sequence number |
| condValid | input | 1 | Store-conditional executed without fault |
| condIdx | input | IDX_W | Slot of that store-conditional |
| reqValid | output | 1 | Cache write request valid |
| reqReady | input | 1 | Cache accepts the request |
| reqIdx | output | IDX_W | Slot being written back |
| reqAddr | output | ADDR_W | Request address |
| reqData | output | DATA_W | Request data |
| reqSize | output | SIZE_W | Request size |
| retry | input | 1 | Cache can take requests again |
| cplValid | input | 1 | Cache completion response |
| cplIdx | input | IDX_W | Slot completed |
| squashValid | input | 1 | Squash request |
| squashSeq | input | SEQ_W | Entries younger than this are removed |
| stallSet | input | 1 | Record a load stalled on a store |
| stallStoreIdx | input | IDX_W | Store slot the load waits on |
| stallLoadIdx | input | LQ_W | Load-queue index of the stalled load |
| replayValid | output | 1 | Stalled load may replay |
| replayLoadIdx | output | LQ_W | Load index to replay |
| headLqTag | output | LQ_W | Load-queue tag of the oldest entry |

## Verification
The main path is exercised with commits that cover several entries at once, with a refusal followed by a retry, with zero-size stores between real ones and with completions in reverse order. This shows whether ordering is kept by the writeback pointer or by the head. A squash that coincides with an issued request, an allocation and a commit shows whether the tail stops at committed work and whether the ignored inputs leave any trace. Random rounds mix sizes, acceptance patterns and completion orders, and each accepted address is compared with program order.

// File: rtl/sq_pkg.sv
package sq_pkg;
  parameter int SEQ_W  = 16;
  parameter int ADDR_W = 32;
  parameter int DATA_W = 32;
  parameter int SIZE_W = 4;
  parameter int LQ_W   = 4;

  typedef logic [SEQ_W-1:0]  seq_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [SIZE_W-1:0] size_t;
  typedef logic [LQ_W-1:0]   lq_t;

  typedef struct packed {
    seq_t  seq;
    addr_t addr;
    size_t size;
    data_t data;
    lq_t   lqTag;
  } sq_entry_t;

  // Strobes from control to payload storage.
  typedef struct packed {
    logic write;
  } sq_strobe_t;
endpackage

// File: rtl/sq_payload.sv
module sq_payload #(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  sq_pkg::sq_strobe_t    strb,
  input  logic [IDX_W-1:0]      wrIdx,
  input  sq_pkg::sq_entry_t     wrEntry,
  input  logic [IDX_W-1:0]      wbIdx,
  input  logic [IDX_W-1:0]      headIdx,
  output sq_pkg::addr_t         wbAddr,
  output sq_pkg::data_t         wbData,
  output sq_pkg::size_t         wbSize,
  output sq_pkg::lq_t           headLqTag,
  output sq_pkg::seq_t          seqAll [SLOTS]
);
  sq_pkg::sq_entry_t mem [SLOTS];

  always_ff @(posedge clk) begin
    if (strb.write) mem[wrIdx] <= wrEntry;
  end

  assign wbAddr    = mem[wbIdx].addr;
  assign wbData    = mem[wbIdx].data;
  assign wbSize    = mem[wbIdx].size;
  assign headLqTag = mem[headIdx].lqTag;

  for (genvar g = 0; g < SLOTS; g++) begin : g_seq
    assign seqAll[g] = mem[g].seq;
  end
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl #(
  parameter int DEPTH = 4,
  parameter int SLOTS = 5,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic               commitValid,
  input  sq_pkg::seq_t       commitSeq,
  input  logic               condValid,
  input  logic [IDX_W-1:0]   condIdx,
  input  logic               squashValid,
  input  sq_pkg::seq_t       squashSeq,
  input  sq_pkg::seq_t       seqAll [SLOTS],
  input  logic               wbZero,
  input  logic               reqReady,
  input  logic               retry,
  input  logic               cplValid,
  input  logic [IDX_W-1:0]   cplIdx,
  input  logic               stallSet,
  input  logic [IDX_W-1:0]   stallStoreIdx,
  input  sq_pkg::lq_t        stallLoadIdx,
  output sq_pkg::sq_strobe_t strb,
  output logic [IDX_W-1:0]   headIdx,
  output logic [IDX_W-1:0]   tailIdx,
  output logic [IDX_W-1:0]   wbIdx,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   pending,
  output logic               full,
  output logic               empty,
  output logic               reqValid,
  output logic               replayValid,
  output sq_pkg::lq_t        replayLoadIdx
);
  logic [IDX_W-1:0] head, tail, wbPtr, stallStore;
  logic [SLOTS-1:0] ready, done, readyN, doneN;
  logic [SLOTS-1:0] occupied, mark, cplHit, keep;
  logic blocked, stalled, wbGo, wbZeroGo, accept, refuse, allocGo, trigger;
  sq_pkg::lq_t stallLoad;
  int hd, tl, occI, retire, keepCnt, nMark, nCpl;

  function automatic logic [IDX_W-1:0] wrapAdd(input logic [IDX_W-1:0] base, input int off);
    int s;
    s = int'(base) + off;
    if (s >= SLOTS) s = s - SLOTS;
    return IDX_W'(s);
  endfunction

  always_comb begin
    hd = int'(head);
    tl = int'(tail);
    occI = (tl >= hd) ? tl - hd : tl + SLOTS - hd;
    full  = (occI == DEPTH);
    empty = (occI == 0);
    wbGo     = (wbPtr != tail) && ready[wbPtr] && (pending != '0) && !blocked;
    wbZeroGo = wbGo && wbZero;
    reqValid = wbGo && !wbZero;
    accept   = reqValid && reqReady;
    refuse   = reqValid && !reqReady;
    allocGo  = allocValid && !full && !squashValid;
    for (int i = 0; i < SLOTS; i++) begin
      int off;
      off = (i >= hd) ? i - hd : i + SLOTS - hd;
      occupied[i] = off < occI;
      mark[i] = !squashValid && occupied[i] && !ready[i] &&
                ((commitValid && (seqAll[i] <= commitSeq)) ||
                 (condValid && (condIdx == IDX_W'(i))));
      cplHit[i] = occupied[i] && !done[i] &&
                  ((cplValid && (cplIdx == IDX_W'(i))) ||
                   (wbZeroGo && (wbPtr == IDX_W'(i))));
      keep[i] = occupied[i] && (ready[i] || (seqAll[i] <= squashSeq));
    end
    readyN = ready | mark;
    doneN  = done | cplHit;
    if (allocGo) begin
      readyN[tail] = 1'b0;
      doneN[tail]  = 1'b0;
    end
    nMark = $countones(mark);
    nCpl  = $countones(cplHit);
    retire  = 0;
    keepCnt = 0;
    for (int off = 0; off < SLOTS; off++) begin
      int idx;
      idx = hd + off;
      if (idx >= SLOTS) idx = idx - SLOTS;
      if (off < occI) begin
        if (doneN[idx] && retire == off) retire = off + 1;
        if (keep[idx]) keepCnt = off + 1;
      end
    end
    trigger = stalled && ((accept && (wbPtr == stallStore)) || cplHit[stallStore]);
    strb.write = allocGo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head <= '0; tail <= '0; wbPtr <= '0;
      ready <= '0; done <= '0; pending <= '0;
      blocked <= 1'b0; stalled <= 1'b0; stallStore <= '0; stallLoad <= '0;
      replayValid <= 1'b0; replayLoadIdx <= '0;
    end else begin
      ready <= readyN;
      done  <= doneN;
      head  <= wrapAdd(head, retire);
      if (squashValid)  tail <= wrapAdd(head, keepCnt);
      else if (allocGo) tail <= wrapAdd(tail, 1);
      if (accept || wbZeroGo) wbPtr <= wrapAdd(wbPtr, 1);
      pending <= pending + CNT_W'(nMark) - CNT_W'(nCpl);
      blocked <= refuse ? 1'b1 : (retry ? 1'b0 : blocked);
      replayValid <= trigger;
      if (trigger) replayLoadIdx <= stallLoad;
      if (stallSet) begin
        stalled    <= 1'b1;
        stallStore <= stallStoreIdx;
        stallLoad  <= stallLoadIdx;
      end else if (trigger) begin
        stalled <= 1'b0;
      end
    end
  end

  assign headIdx = head;
  assign tailIdx = tail;
  assign wbIdx   = wbPtr;
  assign count   = CNT_W'(occI);
endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue #(
  parameter int DEPTH = 4,
  localparam int SLOTS = DEPTH + 1,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        allocValid,
  input  logic [sq_pkg::SEQ_W-1:0]    allocSeq,
  input  logic [sq_pkg::ADDR_W-1:0]   allocAddr,
  input  logic [sq_pkg::SIZE_W-1:0]   allocSize,
  input  logic [sq_pkg::DATA_W-1:0]   allocData,
  input  logic [sq_pkg::LQ_W-1:0]     allocLqTail,
  output logic [IDX_W-1:0]            allocIdx,
  output logic                        full,
  output logic                        empty,
  output logic [CNT_W-1:0]            count,
  output logic [CNT_W-1:0]            pending,
  input  logic                        commitValid,
  input  logic [sq_pkg::SEQ_W-1:0]    commitSeq,
  input  logic                        condValid,
  input  logic [IDX_W-1:0]            condIdx,
  output logic                        reqValid,
  input  logic                        reqReady,
  output logic [IDX_W-1:0]            reqIdx,
  output logic [sq_pkg::ADDR_W-1:0]   reqAddr,
  output logic [sq_pkg::DATA_W-1:0]   reqData,
  output logic [sq_pkg::SIZE_W-1:0]   reqSize,
  input  logic                        retry,
  input  logic                        cplValid,
  input  logic [IDX_W-1:0]            cplIdx,
  input  logic                        squashValid,
  input  logic [sq_pkg::SEQ_W-1:0]    squashSeq,
  input  logic                        stallSet,
  input  logic [IDX_W-1:0]            stallStoreIdx,
  input  logic [sq_pkg::LQ_W-1:0]     stallLoadIdx,
  output logic                        replayValid,
  output logic [sq_pkg::LQ_W-1:0]     replayLoadIdx,
  output logic [sq_pkg::LQ_W-1:0]     headLqTag
);
  sq_pkg::sq_strobe_t strb;
  sq_pkg::sq_entry_t  wrEntry;
  sq_pkg::seq_t       seqAll [SLOTS];
  logic [IDX_W-1:0]   headIdx, tailIdx, wbIdx;

  assign wrEntry = '{seq: allocSeq, addr: allocAddr, size: allocSize,
                     data: allocData, lqTag: allocLqTail};

  sq_payload #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_payload (
    .clk(clk), .strb(strb), .wrIdx(tailIdx), .wrEntry(wrEntry),
    .wbIdx(wbIdx), .headIdx(headIdx), .wbAddr(reqAddr), .wbData(reqData),
    .wbSize(reqSize), .headLqTag(headLqTag), .seqAll(seqAll)
  );

  sq_ctrl #(.DEPTH(DEPTH), .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .condValid(condValid), .condIdx(condIdx),
    .squashValid(squashValid), .squashSeq(squashSeq), .seqAll(seqAll),
    .wbZero(reqSize == '0), .reqReady(reqReady), .retry(retry),
    .cplValid(cplValid), .cplIdx(cplIdx),
    .stallSet(stallSet), .stallStoreIdx(stallStoreIdx), .stallLoadIdx(stallLoadIdx),
    .strb(strb), .headIdx(headIdx), .tailIdx(tailIdx), .wbIdx(wbIdx),
    .count(count), .pending(pending), .full(full), .empty(empty),
    .reqValid(reqValid), .replayValid(replayValid), .replayLoadIdx(replayLoadIdx)
  );

  assign allocIdx = tailIdx;
  assign reqIdx   = wbIdx;
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             full,
  input logic             empty,
  input logic             reqValid,
  input logic             reqReady,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] pending
);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) <= DEPTH);

  assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  assert_empty_no_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !reqValid);

  assert_refuse_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> !reqValid);

  assert_pending_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    pending <= count);
endmodule

bind sq_store_queue sq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_check (
  .clk(clk), .rstN(rstN), .full(full), .empty(empty), .reqValid(reqValid),
  .reqReady(reqReady), .count(count), .pending(pending)
);

// File: tb/sq_store_queue_tb.sv
`timescale 1ns/1ps
module sq_store_queue_tb;
  localparam int DEPTH = 4;
  localparam int IDX_W = 3;
  localparam int CNT_W = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, commitValid = 0, condValid = 0, reqReady = 0, retry = 0;
  logic cplValid = 0, squashValid = 0, stallSet = 0;
  logic [15:0] allocSeq = 0, commitSeq = 0, squashSeq = 0;
  logic [31:0] allocAddr = 0, allocData = 0;
  logic [3:0]  allocSize = 0, allocLqTail = 0, stallLoadIdx = 0;
  logic [IDX_W-1:0] condIdx = 0, cplIdx = 0, stallStoreIdx = 0;
  logic [IDX_W-1:0] allocIdx, reqIdx;
  logic full, empty, reqValid, replayValid;
  logic [CNT_W-1:0] count, pending;
  logic [31:0] reqAddr, reqData;
  logic [3:0]  reqSize, replayLoadIdx, headLqTag;

  int errors = 0, checks = 0;
  logic [31:0] dataA;
  logic [31:0] expQ [8];
  logic [IDX_W-1:0] issued [8];
  int wrp, rdp, nIss;
  logic [15:0] seqCtr;

  always #4 clk = ~clk;

  sq_store_queue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocSeq(allocSeq),
    .allocAddr(allocAddr), .allocSize(allocSize), .allocData(allocData),
    .allocLqTail(allocLqTail), .allocIdx(allocIdx), .full(full), .empty(empty),
    .count(count), .pending(pending), .commitValid(commitValid), .commitSeq(commitSeq),
    .condValid(condValid), .condIdx(condIdx), .reqValid(reqValid), .reqReady(reqReady),
    .reqIdx(reqIdx), .reqAddr(reqAddr), .reqData(reqData), .reqSize(reqSize),
    .retry(retry), .cplValid(cplValid), .cplIdx(cplIdx), .squashValid(squashValid),
    .squashSeq(squashSeq), .stallSet(stallSet), .stallStoreIdx(stallStoreIdx),
    .stallLoadIdx(stallLoadIdx), .replayValid(replayValid),
    .replayLoadIdx(replayLoadIdx), .headLqTag(headLqTag)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic alloc(input logic [15:0] s, input logic [31:0] a, input logic [3:0] sz,
                       input logic [3:0] lq);
    allocValid = 1; allocSeq = s; allocAddr = a; allocSize = sz;
    allocData = $urandom; allocLqTail = lq;
    tick();
    allocValid = 0;
  endtask

  task automatic commit(input logic [15:0] s);
    commitValid = 1; commitSeq = s;
    tick();
    commitValid = 0;
  endtask

  task automatic complete(input logic [IDX_W-1:0] i);
    cplValid = 1; cplIdx = i;
    tick();
    cplValid = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (2) @(posedge clk);
    #2 rstN = 1;
    // R1 reset state
    check("R1", "empty", longint'(empty), 1);
    check("R1", "full", longint'(full), 0);
    check("R1", "count", longint'(count), 0);
    check("R1", "pending", longint'(pending), 0);
    check("R1", "reqValid", longint'(reqValid), 0);
    check("R1", "replayValid", longint'(replayValid), 0);

    // R2 fill to capacity
    alloc(10, 32'h100, 4, 3);
    dataA = allocData;
    alloc(11, 32'h200, 0, 4);
    alloc(12, 32'h300, 4, 5);
    check("R2", "allocIdx", longint'(allocIdx), 3);
    alloc(13, 32'h400, 4, 6);
    check("R2", "count full", longint'(count), 4);
    check("R2", "full", longint'(full), 1);
    alloc(14, 32'h500, 4, 7);
    check("R2", "count after alloc while full", longint'(count), 4);
    check("R2", "allocIdx after alloc while full", longint'(allocIdx), 4);
    check("R3", "headLqTag", longint'(headLqTag), 3);
    check("R4", "no request before commit", longint'(reqValid), 0);

    // R4 commit two entries, R6 request, R7 refuse and retry
    commit(11);
    check("R4", "pending after commit", longint'(pending), 2);
    check("R6", "reqValid", longint'(reqValid), 1);
    check("R6", "reqAddr", longint'(reqAddr), 32'h100);
    check("R6", "reqData", longint'(reqData), longint'(dataA));
    check("R6", "reqIdx", longint'(reqIdx), 0);
    tick();
    check("R7", "quiet after refusal", longint'(reqValid), 0);
    tick();
    check("R7", "still blocked", longint'(reqValid), 0);
    retry = 1; tick(); retry = 0;
    check("R7", "reissue after retry", longint'(reqValid), 1);
    check("R7", "same entry", longint'(reqIdx), 0);
    reqReady = 1; tick();
    check("R8", "no request for zero-size", longint'(reqValid), 0);
    check("R8", "pending before zero completes", longint'(pending), 2);
    tick();
    check("R8", "pending after zero completes", longint'(pending), 1);
    check("R9", "count while head incomplete", longint'(count), 4);
    complete(0);
    check("R9", "count after head completes", longint'(count), 2);
    check("R12", "pending after completion", longint'(pending), 0);
    check("R3", "headLqTag after retire", longint'(headLqTag), 5);

    // R10 squash together with issue, alloc and commit
    commit(12);
    check("R6", "reqAddr third", longint'(reqAddr), 32'h300);
    squashValid = 1; squashSeq = 11;
    allocValid = 1; allocSeq = 99; commitValid = 1; commitSeq = 13;
    tick();
    squashValid = 0; allocValid = 0; commitValid = 0;
    check("R10", "count after squash", longint'(count), 1);
    check("R10", "commit ignored", longint'(pending), 1);
    check("R10", "alloc ignored", longint'(allocIdx), 3);
    check("R10", "no request", longint'(reqValid), 0);
    complete(2);
    check("R9", "empty", longint'(empty), 1);
    check("R12", "pending zero", longint'(pending), 0);

    // R9 out-of-order completion
    alloc(20, 32'h500, 2, 1);
    alloc(21, 32'h600, 8, 1);
    commit(21);
    check("R6", "first of pair", longint'(reqIdx), 3);
    tick();
    check("R6", "second of pair idx", longint'(reqIdx), 4);
    check("R6", "second of pair addr", longint'(reqAddr), 32'h600);
    tick();
    complete(4);
    check("R9", "younger completion keeps slot", longint'(count), 2);
    complete(3);
    check("R9", "both retire", longint'(count), 0);

    // R5 store-conditional
    reqReady = 0;
    alloc(30, 32'h700, 4, 2);
    condValid = 1; condIdx = 0; tick(); condValid = 0;
    check("R5", "pending", longint'(pending), 1);
    check("R5", "request", longint'(reqAddr), 32'h700);
    reqReady = 1; tick();
    complete(0);
    check("R5", "drained", longint'(count), 0);

    // R11 replay on acceptance
    alloc(40, 32'h800, 4, 2);
    stallSet = 1; stallStoreIdx = 1; stallLoadIdx = 7; tick(); stallSet = 0;
    reqReady = 0;
    commit(40);
    check("R11", "no replay yet", longint'(replayValid), 0);
    reqReady = 1; tick();
    check("R11", "replay on accept", longint'(replayValid), 1);
    check("R11", "replay index", longint'(replayLoadIdx), 7);
    tick();
    check("R11", "replay single pulse", longint'(replayValid), 0);
    complete(1);

    // R11 replay on zero-size completion
    alloc(41, 32'h900, 0, 2);
    stallSet = 1; stallStoreIdx = 2; stallLoadIdx = 9; tick(); stallSet = 0;
    commit(41);
    check("R11", "no replay before zero completes", longint'(replayValid), 0);
    tick();
    check("R11", "replay on completion", longint'(replayValid), 1);
    check("R11", "replay index zero-size", longint'(replayLoadIdx), 9);
    check("R8", "zero-size retired", longint'(count), 0);

    // Random rounds: R6 ordering, R9/R12 drain
    seqCtr = 100;
    retry = 1;
    for (int round = 0; round < 20; round++) begin
      int n;
      n = 1 + int'($urandom % 4);
      wrp = 0; rdp = 0; nIss = 0;
      for (int k = 0; k < n; k++) begin
        logic [3:0] sz;
        logic [31:0] a;
        sz = ($urandom % 3 == 0) ? 4'd0 : 4'(1 + $urandom % 8);
        a = $urandom;
        if (sz != 0) begin expQ[wrp] = a; wrp++; end
        alloc(seqCtr, a, sz, 0);
        seqCtr++;
      end
      commit(seqCtr - 1);
      for (int c = 0; c < 40; c++) begin
        reqReady = $urandom % 2;
        if (reqValid && reqReady) begin
          check("R6", "random order addr", longint'(reqAddr), longint'(expQ[rdp]));
          issued[nIss] = reqIdx;
          nIss++; rdp++;
        end
        tick();
      end
      reqReady = 0;
      check("R6", "all sent", longint'(rdp), longint'(wrp));
      for (int j = nIss - 1; j >= 0; j--) complete(issued[j]);
      check("R9", "random drain count", longint'(count), 0);
      check("R12", "random drain pending", longint'(pending), 0);
    end
    retry = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule